// File: doc/BRIEF.md
# Three-Phase Complementary PWM Timer

This timer drives three half-bridge legs of a motor inverter. Each leg has a positive-phase output and a negative-phase output. A triangular carrier sweeps up to a programmable half period and back down. Each output of a pair is compared against that phase's duty value.

The carrier is formed by two counters that step in lockstep, with a fixed offset equal to the dead time. The positive output is tested against the leading counter and the negative output against the trailing one. As a result, a gap of exactly the dead time separates every hand-over between the two outputs of a pair, and both can never be active in the same cycle.

Software writes the duty and half-period values into buffer inputs at any time. The active copies take them over only at the crest or the trough of the carrier, so no pulse is ever cut short. Dead time, polarity and the pin enables are set while the timer is stopped. A start strobe then launches both counters together, and a stop strobe halts them. An optional output flips once per carrier period.

Top module: `cpwm3_timer`

## Requirements
- R1: While reset is asserted and after it is released, every PWM output sits at its inactive level (the inverse of its polarity input) and the toggle output is 0.
- R2: While stopped, all six PWM outputs stay inactive. A start strobe while stopped loads the leading counter with the dead time and the trailing counter with 0, and copies the buffered half period and duties into the active registers.
- R3: Once running, the trailing counter value c follows 0,1,…,H,H−1,…,1 and repeats, with a period of 2H cycles, where H is the active half period (H ≥ 2). The leading counter always equals c plus the dead time.
- R4: For phase i (duty in bits [16i+15:16i] of the duty input), the positive output is active when c + D < duty and the negative output is active when c ≥ duty, where D is the dead time latched at start. So duty 0 gives a permanently active negative output, and a duty above H + D gives a permanently active positive output.
- R5: The positive and negative outputs of a phase are never active in the same cycle.
- R6: A duty or half-period value written while running takes effect only on the cycle after the carrier reaches its crest (c = H) or its trough (c = 0).
- R7: Positive outputs are active-high when the positive polarity input is 1 and active-low when it is 0. The negative polarity input controls the negative outputs in the same way.
- R8: Pin-enable bit i (0 to 2) gates the positive output of phase i, and bit 3+i gates the negative output of phase i. A pin whose bit is 0 is held at its inactive level.
- R9: With the toggle enable at 0, the toggle output holds its value.
- R10: Changing the dead-time input while running has no effect until the next start.
- R11: A stop strobe halts both counters on the next edge and returns all PWM outputs to inactive. The toggle output then stays constant.
- R12: With the toggle enable at 1, the toggle output flips on the edge that leaves each trough, that is, one cycle after start and then every 2H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both counters |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, acts only while stopped |
| stop_i | input | 1 | Stop strobe, acts only while running |
| dead_i | input | CW | Dead time in clock cycles |
| half_i | input | CW | Buffered half carrier period |
| duty_i | input | 3*CW | Buffered duty values, phase i in slice i |
| pol_pos_i | input | 1 | Active level of the positive outputs |
| pol_neg_i | input | 1 | Active level of the negative outputs |
| pin_en_i | input | 6 | Per-pin output enable, positive bits [2:0], negative bits [5:3] |
| tgl_en_i | input | 1 | Enable for the period toggle output |
| pos_o | output | 3 | Positive-phase PWM outputs |
| neg_o | output | 3 | Negative-phase PWM outputs |
| tgl_o | output | 1 | Toggle output, flips once per carrier period |

## Verification
A wrong counter offset or a stale dead time shows at the ports within one carrier period. It shortens or lengthens every gap between a positive and a negative pulse, so the active-cycle counts taken over a full period no longer match the closed form. A slip in the up/down turnaround moves the toggle output's flip away from its expected 2H spacing on the very next trough. A buffer copied at the wrong moment changes a phase's level in the same cycle the new duty is written, instead of after the crest, so a sample taken between the write and the crest catches it.

// File: rtl/cpwm3_timer.sv
module cpwm3_timer #(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CW-1:0]     dead_i,
  input  logic [CW-1:0]     half_i,
  input  logic [NPH*CW-1:0] duty_i,
  input  logic              pol_pos_i,
  input  logic              pol_neg_i,
  input  logic [2*NPH-1:0]  pin_en_i,
  input  logic              tgl_en_i,
  output logic [NPH-1:0]    pos_o,
  output logic [NPH-1:0]    neg_o,
  output logic              tgl_o
);

  logic          run, up;
  logic [CW-1:0] cnt_a, cnt_b, dt, h_act;
  logic [CW-1:0] duty_act [NPH];
  logic [CW:0]   b_nxt;
  logic          crest, trough;

  assign b_nxt  = {1'b0, cnt_b} + {{CW{1'b0}}, 1'b1};
  assign crest  = run && (cnt_b == h_act);
  assign trough = run && (cnt_b == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run   <= 1'b0;
      up    <= 1'b1;
      cnt_a <= '0;
      cnt_b <= '0;
      dt    <= '0;
      h_act <= '0;
      tgl_o <= 1'b0;
      for (int i = 0; i < NPH; i++) duty_act[i] <= '0;
    end else if (!run) begin
      if (start_i) begin
        run   <= 1'b1;
        up    <= 1'b1;
        dt    <= dead_i;
        cnt_a <= dead_i;
        cnt_b <= '0;
        h_act <= half_i;
        for (int i = 0; i < NPH; i++) duty_act[i] <= duty_i[i*CW +: CW];
      end
    end else if (stop_i) begin
      run <= 1'b0;
    end else begin
      if (up) begin
        cnt_a <= cnt_a + 1'b1;
        cnt_b <= cnt_b + 1'b1;
        if (b_nxt >= {1'b0, h_act}) up <= 1'b0;
      end else begin
        cnt_a <= cnt_a - 1'b1;
        cnt_b <= cnt_b - 1'b1;
        if (cnt_b == {{(CW-1){1'b0}}, 1'b1}) up <= 1'b1;
      end
      if (crest || trough) begin
        h_act <= half_i;
        for (int i = 0; i < NPH; i++) duty_act[i] <= duty_i[i*CW +: CW];
      end
      if (trough && tgl_en_i) tgl_o <= ~tgl_o;
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    logic pos_act, neg_act;
    assign pos_act  = run && (cnt_a < duty_act[g]);
    assign neg_act  = run && (cnt_b >= duty_act[g]);
    assign pos_o[g] = (pin_en_i[g] && pos_act) ? pol_pos_i : ~pol_pos_i;
    assign neg_o[g] = (pin_en_i[NPH+g] && neg_act) ? pol_neg_i : ~pol_neg_i;

    p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pos_act && neg_act));
    p_duty_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run && !crest && !trough |=> $stable(duty_act[g]));
  end

  p_offset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt_a - cnt_b) == dt);
  p_rise_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && up |-> cnt_b <= h_act);
  p_half_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !crest && !trough |=> $stable(h_act));
  p_dead_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> $stable(dt));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !start_i |=> $stable(cnt_b) && $stable(tgl_o));
  p_tgl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgl_en_i |=> $stable(tgl_o));

endmodule

// File: tb/cpwm3_timer_bench.sv
`timescale 1ns/1ps
module cpwm3_timer_bench;
  localparam int CW = 16;
  localparam real TCK = 5.0;

  logic clk = 0, rst_n = 0, start = 0, stop = 0, pp = 1, pn = 1, ten = 0;
  logic [CW-1:0] dead = '0, half = 16'd4;
  logic [3*CW-1:0] duty = '0;
  logic [5:0] en = 6'h3f;
  logic [2:0] pos, neg;
  logic tgl;
  int n_run = 0, n_fail = 0;

  always #(TCK/2) clk = ~clk;

  cpwm3_timer u_cpwm3_timer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .dead_i(dead), .half_i(half), .duty_i(duty), .pol_pos_i(pp),
    .pol_neg_i(pn), .pin_en_i(en), .tgl_en_i(ten),
    .pos_o(pos), .neg_o(neg), .tgl_o(tgl));

  // D, H, duty u, duty v, duty w, pos polarity, neg polarity
  localparam logic [55:0] VEC [5] = '{
    {8'd2, 8'd8,  8'd5, 8'd0,  8'd20, 8'd1, 8'd1},
    {8'd0, 8'd4,  8'd2, 8'd3,  8'd1,  8'd1, 8'd0},
    {8'd3, 8'd10, 8'd7, 8'd12, 8'd4,  8'd0, 8'd1},
    {8'd1, 8'd6,  8'd6, 8'd7,  8'd2,  8'd0, 8'd0},
    {8'd4, 8'd5,  8'd9, 8'd5,  8'd3,  8'd1, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_start();
    start = 1; step(); start = 0;
  endtask

  task automatic do_stop();
    stop = 1; step(); stop = 0;
  endtask

  function automatic int exp_cnt(int d, int h, int du, bit is_pos);
    int n = 0;
    for (int k = 0; k < 2*h; k++) begin
      int c = (k <= h) ? k : 2*h - k;
      if (is_pos ? (c + d < du) : (c >= du)) n++;
    end
    return n;
  endfunction

  initial begin
    #(TCK*200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: levels during reset
    chk(pos == 3'b000 && neg == 3'b000 && tgl == 0, "R1 in reset", {tgl, neg, pos}, 0);
    step(); rst_n = 1; step();
    chk(pos == 3'b000 && neg == 3'b000 && tgl == 0, "R1 after reset", {tgl, neg, pos}, 0);
    // R2: idle with duties that would drive both sides
    duty = {16'd2, 16'd0, 16'd9};
    step(); step();
    chk(pos == 3'b000 && neg == 3'b000, "R2 idle inactive", {neg, pos}, 0);

    // R4 R7 R10 R5: table of vectors, one full period each
    foreach (VEC[vi]) begin
      int d  = VEC[vi][55:48];
      int h  = VEC[vi][47:40];
      int du [3];
      int cp [3];
      int cn [3];
      int ovl = 0;
      du[0] = VEC[vi][39:32]; du[1] = VEC[vi][31:24]; du[2] = VEC[vi][23:16];
      pp = VEC[vi][8]; pn = VEC[vi][0];
      dead = CW'(d); half = CW'(h);
      duty = {CW'(du[2]), CW'(du[1]), CW'(du[0])};
      en = 6'h3f;
      step();
      do_start();
      dead = CW'(d + 7);
      for (int i = 0; i < 3; i++) begin cp[i] = 0; cn[i] = 0; end
      for (int k = 0; k < 2*h; k++) begin
        for (int i = 0; i < 3; i++) begin
          if (pos[i] == pp) cp[i]++;
          if (neg[i] == pn) cn[i]++;
          if (pos[i] == pp && neg[i] == pn) ovl++;
        end
        step();
      end
      for (int i = 0; i < 3; i++) begin
        chk(cp[i] == exp_cnt(d, h, du[i], 1), "R4 R7 R10 positive count", cp[i], exp_cnt(d, h, du[i], 1));
        chk(cn[i] == exp_cnt(d, h, du[i], 0), "R4 R7 R10 negative count", cn[i], exp_cnt(d, h, du[i], 0));
      end
      chk(ovl == 0, "R5 overlap cycles", ovl, 0);
      do_stop();
    end

    // R12 R3: toggle period with H=3
    begin
      logic t0;
      pp = 1; pn = 1; dead = 16'd1; half = 16'd3; duty = {3{16'd2}}; ten = 1;
      step();
      do_start();
      t0 = tgl;
      step();
      chk(tgl == ~t0, "R12 flip after start", tgl, ~t0);
      repeat (5) step();
      chk(tgl == ~t0, "R3 R12 held until trough", tgl, ~t0);
      step();
      chk(tgl == t0, "R3 R12 flip after 2H", tgl, t0);
      do_stop();
    end

    // R9: toggle disabled holds
    begin
      logic t1;
      ten = 0; step();
      do_start();
      t1 = tgl;
      repeat (10) step();
      chk(tgl == t1, "R9 toggle held", tgl, t1);
      do_stop();
    end

    // R8: pin enables, pos U and neg W enabled only
    begin
      int bad = 0;
      int cu = 0;
      dead = 16'd1; half = 16'd6; duty = {3{16'd4}}; en = 6'b100_001;
      step();
      do_start();
      for (int k = 0; k < 12; k++) begin
        if (pos[1] || pos[2] || neg[0] || neg[1]) bad++;
        if (pos[0]) cu++;
        step();
      end
      chk(bad == 0, "R8 disabled pins active", bad, 0);
      chk(cu == exp_cnt(1, 6, 4, 1), "R8 enabled pin count", cu, exp_cnt(1, 6, 4, 1));
      do_stop();
      en = 6'h3f;
    end

    // R6: buffered duty takes effect after crest
    dead = 16'd2; half = 16'd8; duty = {3{16'd5}};
    step();
    do_start();
    step(); step();
    duty = {16'd5, 16'd5, 16'd9};
    step();
    chk(pos[0] == 1'b0, "R6 old duty kept mid ramp", pos[0], 0);
    repeat (5) step();
    chk(neg[0] == 1'b1, "R6 old duty at crest", neg[0], 1);
    step();
    chk(neg[0] == 1'b0 && pos[0] == 1'b0, "R6 new duty after crest", {neg[0], pos[0]}, 0);

    // R11: stop returns outputs to inactive and freezes toggle
    begin
      logic t2;
      ten = 1;
      do_stop();
      t2 = tgl;
      chk(pos == 3'b000 && neg == 3'b000, "R11 inactive after stop", {neg, pos}, 0);
      repeat (20) step();
      chk(tgl == t2 && pos == 3'b000 && neg == 3'b000, "R11 frozen while stopped", {tgl, neg, pos}, {t2, 6'b0});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule